// File: doc/BRIEF.md
# Two-Layer Overlay Compositor with Colour Key

This block builds the pixel stream for one display output from two aligned input layers, a graphics layer and a video layer, placed over a programmable solid background colour. It handles one pixel per clock. The layers stack from bottom to top as background, then graphics, then video. Each layer's valid flag says whether that layer covers the current pixel.

A transparency colour key can remove pixels from one layer. In destination mode the key is compared with the graphics pixel, and a matching graphics pixel disappears so that the video or background beneath it shows. In source mode the key is compared with the video pixel, and a matching video pixel is discarded so that the graphics or background shows. On top of the keying, global alpha blending can be switched on with its own enable. Each layer then carries a constant 8-bit opacity and is mixed over whatever lies beneath it.

The result is registered with a fixed latency of two cycles. The display-enable and sync flags are delayed to match.

Top module: `ovl_mixer`

## Requirements
- R1: While reset is asserted, out_vld, out_sync and out_px are all zero.
- R2: out_vld and out_sync equal in_de and in_sync from exactly two clock cycles earlier. out_px is the composite of the inputs and settings sampled in that same cycle.
- R3: With blending off, a shown video pixel wins over a shown graphics pixel, and a shown graphics pixel wins over the background.
- R4: When neither layer is valid, out_px equals bg_color.
- R5: With key_en low, no pixel is removed, even when it equals key_color.
- R6: With key_en high and key_src = 0 (destination mode), a valid graphics pixel equal to key_color is removed, so video shows where video is valid and bg_color shows otherwise. A video pixel equal to the key is not removed in this mode.
- R7: With key_en high and key_src = 1 (source mode), a valid video pixel equal to key_color is removed, so graphics shows where graphics is valid and bg_color shows otherwise. A graphics pixel equal to the key is not removed in this mode.
- R8: With blend_en high, the composite is built from the bottom up. Graphics is mixed over the background with gfx_alpha, and then video is mixed over that result with vid_alpha. Each channel (bits 23:16, 15:8, 7:0) is mixed independently as (a*top + (255-a)*below + 127) / 255, rounded down.
- R9: With blending on, an alpha of 0xFF passes the layer's pixel through exactly, and an alpha of 0x00 passes the colour beneath it through exactly.
- R10: With blend_en low, the values of gfx_alpha and vid_alpha have no effect on out_px.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_de | input | 1 | Display enable for the input pixel |
| in_sync | input | 2 | Sync flags, delayed unchanged to the output |
| gfx_vld | input | 1 | Graphics layer covers this pixel |
| gfx_px | input | 24 | Graphics pixel |
| vid_vld | input | 1 | Video layer covers this pixel |
| vid_px | input | 24 | Video pixel |
| key_color | input | 24 | Transparency key colour |
| key_en | input | 1 | Colour key enable |
| key_src | input | 1 | 0: key matched on graphics, 1: key matched on video |
| bg_color | input | 24 | Solid background colour |
| blend_en | input | 1 | Global alpha blending enable |
| gfx_alpha | input | 8 | Graphics opacity, 0xFF opaque |
| vid_alpha | input | 8 | Video opacity, 0xFF opaque |
| out_vld | output | 1 | Delayed display enable |
| out_sync | output | 2 | Delayed sync flags |
| out_px | output | 24 | Composited pixel |

## Verification
The input patterns cover every combination of the two valid flags with blending off, which shows whether the layer priority is correct. Pixels equal to the key are sent on each layer, in both key modes and with the key disabled, so that keying of the wrong layer and keying while disabled each give a visibly wrong colour. Blended pixels use a different value in each channel and alphas of 0x00, 0x40, 0x80 and 0xFF, which exposes channel swaps, rounding errors and a wrong mixing order. Back-to-back pixels mixed with blanking cycles that toggle the sync flags confirm that pixels, valid and sync stay aligned at the fixed latency.

// File: rtl/ovl_mixer.sv
module ovl_mixer #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_de,
  input  logic [1:0]      in_sync,
  input  logic            gfx_vld,
  input  logic [3*CW-1:0] gfx_px,
  input  logic            vid_vld,
  input  logic [3*CW-1:0] vid_px,
  input  logic [3*CW-1:0] key_color,
  input  logic            key_en,
  input  logic            key_src,
  input  logic [3*CW-1:0] bg_color,
  input  logic            blend_en,
  input  logic [CW-1:0]   gfx_alpha,
  input  logic [CW-1:0]   vid_alpha,
  output logic            out_vld,
  output logic [1:0]      out_sync,
  output logic [3*CW-1:0] out_px
);
  localparam int PW   = 3 * CW;
  localparam int SW   = 2 * CW + 1;
  localparam int HALF = ((1 << CW) - 1) / 2;

  function automatic logic [CW-1:0] mix(input logic [CW-1:0] a, input logic [CW-1:0] t,
                                        input logic [CW-1:0] b);
    logic [CW-1:0] na;
    logic [SW-1:0] s;
    logic [SW-1:0] q;
    na = ~a;
    s  = SW'(a) * SW'(t) + SW'(na) * SW'(b) + SW'(HALF);
    q  = (s + (s >> CW) + SW'(1)) >> CW;
    return q[CW-1:0];
  endfunction

  wire gfx_hit  = key_en && !key_src && (gfx_px == key_color);
  wire vid_hit  = key_en &&  key_src && (vid_px == key_color);
  wire gfx_show = gfx_vld && !gfx_hit;
  wire vid_show = vid_vld && !vid_hit;

  logic          s1_de, s1_gs, s1_vs, s1_bl;
  logic [1:0]    s1_sync;
  logic [PW-1:0] s1_g, s1_v, s1_bg;
  logic [CW-1:0] s1_ga, s1_va;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_de   <= 1'b0;
      s1_sync <= '0;
      s1_gs   <= 1'b0;
      s1_vs   <= 1'b0;
      s1_bl   <= 1'b0;
      s1_g    <= '0;
      s1_v    <= '0;
      s1_bg   <= '0;
      s1_ga   <= '0;
      s1_va   <= '0;
    end else begin
      s1_de   <= in_de;
      s1_sync <= in_sync;
      s1_gs   <= gfx_show;
      s1_vs   <= vid_show;
      s1_bl   <= blend_en;
      s1_g    <= gfx_px;
      s1_v    <= vid_px;
      s1_bg   <= bg_color;
      s1_ga   <= gfx_alpha;
      s1_va   <= vid_alpha;
    end
  end

  logic [PW-1:0] comp;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    wire [CW-1:0] bgc = s1_bg[c*CW +: CW];
    wire [CW-1:0] gc  = s1_g[c*CW +: CW];
    wire [CW-1:0] vc  = s1_v[c*CW +: CW];
    wire [CW-1:0] lo  = !s1_gs ? bgc : (s1_bl ? mix(s1_ga, gc, bgc) : gc);
    assign comp[c*CW +: CW] = !s1_vs ? lo : (s1_bl ? mix(s1_va, vc, lo) : vc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_sync <= '0;
      out_px   <= '0;
    end else begin
      out_vld  <= s1_de;
      out_sync <= s1_sync;
      out_px   <= comp;
    end
  end
endmodule

module ovl_mixer_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_de,
  input logic [1:0]      in_sync,
  input logic            gfx_vld,
  input logic [3*CW-1:0] gfx_px,
  input logic            vid_vld,
  input logic [3*CW-1:0] vid_px,
  input logic [3*CW-1:0] key_color,
  input logic            key_en,
  input logic            key_src,
  input logic [3*CW-1:0] bg_color,
  input logic            blend_en,
  input logic [CW-1:0]   vid_alpha,
  input logic            out_vld,
  input logic [1:0]      out_sync,
  input logic [3*CW-1:0] out_px
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_vld && out_sync == 2'b00 && out_px == '0));

  a_r2_de_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_de |=> ##1 out_vld);

  a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ##1 (out_sync == $past(in_sync, 2)));

  a_r3_video_top: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_vld && !blend_en && !key_en) |=> ##1 (out_px == $past(vid_px, 2)));

  a_r4_background: assert property (@(posedge clk) disable iff (!rst_n)
    (!gfx_vld && !vid_vld) |=> ##1 (out_px == $past(bg_color, 2)));

  a_r6_dest_key: assert property (@(posedge clk) disable iff (!rst_n)
    (key_en && !key_src && gfx_vld && gfx_px == key_color && !vid_vld)
      |=> ##1 (out_px == $past(bg_color, 2)));

  a_r7_src_key: assert property (@(posedge clk) disable iff (!rst_n)
    (key_en && key_src && vid_vld && vid_px == key_color && !gfx_vld)
      |=> ##1 (out_px == $past(bg_color, 2)));

  a_r9_opaque_video: assert property (@(posedge clk) disable iff (!rst_n)
    (blend_en && vid_vld && vid_alpha == '1 && !key_en)
      |=> ##1 (out_px == $past(vid_px, 2)));
endmodule

bind ovl_mixer ovl_mixer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_de(in_de), .in_sync(in_sync),
  .gfx_vld(gfx_vld), .gfx_px(gfx_px), .vid_vld(vid_vld), .vid_px(vid_px),
  .key_color(key_color), .key_en(key_en), .key_src(key_src), .bg_color(bg_color),
  .blend_en(blend_en), .vid_alpha(vid_alpha),
  .out_vld(out_vld), .out_sync(out_sync), .out_px(out_px)
);

// File: tb/sim_ovl_mixer.sv
module sim_ovl_mixer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_de = 1'b0;
  logic [1:0]  in_sync = 2'b00;
  logic        gfx_vld = 1'b0, vid_vld = 1'b0;
  logic [23:0] gfx_px = '0, vid_px = '0;
  logic [23:0] key_color = 24'h00FF00, bg_color = 24'h102030;
  logic        key_en = 1'b0, key_src = 1'b0, blend_en = 1'b0;
  logic [7:0]  gfx_alpha = 8'h00, vid_alpha = 8'h00;
  logic        out_vld;
  logic [1:0]  out_sync;
  logic [23:0] out_px;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  logic [23:0] q_px[$];
  logic [1:0]  q_sync[$];
  logic        q_de[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  ovl_mixer u0 (
    .clk(clk), .rst_n(rst_n), .in_de(in_de), .in_sync(in_sync),
    .gfx_vld(gfx_vld), .gfx_px(gfx_px), .vid_vld(vid_vld), .vid_px(vid_px),
    .key_color(key_color), .key_en(key_en), .key_src(key_src), .bg_color(bg_color),
    .blend_en(blend_en), .gfx_alpha(gfx_alpha), .vid_alpha(vid_alpha),
    .out_vld(out_vld), .out_sync(out_sync), .out_px(out_px)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int mixc(int a, int t, int b);
    return (a * t + (255 - a) * b + 127) / 255;
  endfunction

  function automatic logic [23:0] model();
    logic g_on, v_on;
    logic [23:0] r;
    g_on = gfx_vld && !(key_en && !key_src && gfx_px == key_color);
    v_on = vid_vld && !(key_en && key_src && vid_px == key_color);
    for (int c = 0; c < 3; c++) begin
      int lo, tp;
      lo = bg_color[c*8 +: 8];
      if (g_on) lo = blend_en ? mixc(gfx_alpha, gfx_px[c*8 +: 8], lo) : int'(gfx_px[c*8 +: 8]);
      tp = lo;
      if (v_on) tp = blend_en ? mixc(vid_alpha, vid_px[c*8 +: 8], lo) : int'(vid_px[c*8 +: 8]);
      r[c*8 +: 8] = tp[7:0];
    end
    return r;
  endfunction

  task automatic drive(string tag, logic gv, logic [23:0] gp, logic vv, logic [23:0] vp,
                       logic de = 1'b1, logic [1:0] sy = 2'b00);
    gfx_vld = gv; gfx_px = gp; vid_vld = vv; vid_px = vp; in_de = de; in_sync = sy;
    q_px.push_back(model());
    q_sync.push_back(sy);
    q_de.push_back(de);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && q_cyc.size() > 0 && q_cyc[0] + 2 <= cyc) begin
      string t;
      logic d;
      t = q_tag.pop_front();
      d = q_de.pop_front();
      chk({t, "/R2 timing"}, q_cyc.pop_front() + 2, cyc);
      chk({t, "/R2 vld"}, 32'(out_vld), 32'(d));
      chk({t, "/R2 sync"}, 32'(out_sync), 32'(q_sync.pop_front()));
      if (d) chk(t, 32'(out_px), 32'(q_px.pop_front()));
      else void'(q_px.pop_front());
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 vld", 32'(out_vld), 0);
    chk("R1 sync", 32'(out_sync), 0);
    chk("R1 px", 32'(out_px), 0);
    rst_n = 1'b1;
    @(negedge clk);

    drive("R4 empty", 0, 24'h111111, 0, 24'h222222);
    drive("R3 gfx only", 1, 24'hA1B2C3, 0, 24'h222222);
    drive("R3 vid only", 0, 24'hA1B2C3, 1, 24'h445566);
    drive("R3 both", 1, 24'hA1B2C3, 1, 24'h445566);
    drive("R2 blank", 1, 24'h010203, 1, 24'h040506, 1'b0, 2'b01);
    drive("R2 blank", 0, 24'h010203, 0, 24'h040506, 1'b0, 2'b11);
    drive("R2 blank", 0, 24'h010203, 0, 24'h040506, 1'b0, 2'b10);

    drive("R5 off gfx", 1, 24'h00FF00, 0, 24'h0);
    drive("R5 off vid", 0, 24'h0, 1, 24'h00FF00);

    key_en = 1'b1; key_src = 1'b0;
    drive("R6 dest to vid", 1, 24'h00FF00, 1, 24'h778899);
    drive("R6 dest to bg", 1, 24'h00FF00, 0, 24'h778899);
    drive("R6 dest nomatch", 1, 24'h00FF01, 0, 24'h778899);
    drive("R6 vid kept", 0, 24'h0, 1, 24'h00FF00);

    key_src = 1'b1;
    drive("R7 src to gfx", 1, 24'hC0FFEE, 1, 24'h00FF00);
    drive("R7 src to bg", 0, 24'hC0FFEE, 1, 24'h00FF00);
    drive("R7 gfx kept", 1, 24'h00FF00, 0, 24'h0);

    key_en = 1'b0; blend_en = 1'b1; gfx_alpha = 8'h80; vid_alpha = 8'h40;
    drive("R8 gfx mix", 1, 24'hFF8001, 0, 24'h0);
    drive("R8 vid mix", 0, 24'h0, 1, 24'h01FF7F);
    drive("R8 stack", 1, 24'hFF8001, 1, 24'h01FF7F);
    drive("R8 stack2", 1, 24'h20E0C8, 1, 24'hF0100A);
    key_en = 1'b1; key_src = 1'b0;
    drive("R8 key+mix", 1, 24'h00FF00, 1, 24'h01FF7F);
    key_en = 1'b0;

    vid_alpha = 8'hFF; gfx_alpha = 8'h00;
    drive("R9 vid opaque", 1, 24'h123456, 1, 24'hFEDCBA);
    drive("R9 gfx clear", 1, 24'h123456, 0, 24'h0);
    vid_alpha = 8'h00; gfx_alpha = 8'hFF;
    drive("R9 vid clear", 1, 24'h123456, 1, 24'hFEDCBA);
    drive("R9 gfx opaque", 1, 24'h123456, 0, 24'h0);

    blend_en = 1'b0; gfx_alpha = 8'h10; vid_alpha = 8'h20;
    drive("R10 alpha ign", 1, 24'h55AA55, 1, 24'hAA55AA, 1'b1, 2'b10);
    drive("R10 alpha ign", 1, 24'h55AA55, 0, 24'hAA55AA, 1'b1, 2'b01);

    in_de = 1'b0; gfx_vld = 1'b0; vid_vld = 1'b0; in_sync = 2'b00;
    repeat (4) @(negedge clk);
    chk("R2 drained", q_cyc.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule